// File: doc/BRIEF.md
# Switch State Register Peripheral

This peripheral holds one 32-bit switch state and presents it to a host through a small word-addressed register window of 4 KiB, together with a single level-sensitive interrupt. Logic on the hardware side can load a new state at any time through a set port. Every load marks the state as changed. If interrupts are enabled, the load also raises the interrupt line. The host learns about changes by reading an interrupt status register. That read reports the change and consumes it in the same access.

A build-time parameter makes the switch output-capable. On an output-capable switch, a host write to the state register is not stored directly. It is offered to the hardware side as a request, and the host bus stalls until the hardware side acknowledges with the value it actually applied. That resolved value updates the state through the same path as a hardware load, but only when it differs from the current state. A write to the name-pointer register does no copying. It only emits a one-cycle copy request that carries the written address. Illegal accesses complete at once with an error pulse and set a sticky error flag. Apart from that they change nothing.

Top module: `sw_state_periph`

## Requirements
- R1: After a synchronous active-low reset the state reads 0, no change is pending, interrupts are disabled, `irq` is low, `err_sticky` is low and `out_req` is low.
- R2: A read of offset 0x00 returns the `NAME_LEN` parameter. A read of offset 0x08 returns `OUT_CAP` in bit 0 and zeros above it.
- R3: A cycle with `hw_set_valid` high stores `hw_set_value` as the state, which is then readable at offset 0x0C. It also marks a change, and `irq` is high the following cycle when the enable bit is 1. When the enable bit is 0, `irq` stays low.
- R4: A read of offset 0x10 returns 1 only when a change is pending and the enable bit is 1. In that case the pending change is cleared and `irq` is low the next cycle. In every other case the read returns 0 and leaves the change flag and `irq` untouched.
- R5: A write to offset 0x14 keeps only bit 0 as the new enable bit. While a change is pending, `irq` follows the written enable value from the next cycle. With no change pending, `irq` stays low.
- R6: On an output-capable switch, a write to 0x0C drives `out_req` high with `out_value` equal to the written data. `host_ready` is held low until a cycle with `out_ack` high. The value on `out_resolved` in that cycle becomes the state and marks a change only if it differs from the stored state. If it equals the stored state, nothing changes.
- R7: An error is a write to 0x0C on an input-only switch, a read of 0x04 or 0x14, a write to 0x00, 0x08 or 0x10, or any access to another address, including unaligned ones. An error completes in the same cycle with `host_err` high and read data 0, sets `err_sticky` until reset, and has no other effect.
- R8: A write to 0x04 makes `name_copy_req` high for exactly the next cycle, with `name_copy_addr` equal to the written data.
- R9: When `hw_set_valid` coincides with a read of 0x10, the read still returns the pre-cycle status. The set wins: the change stays pending, and `irq` is high next cycle if the enable bit is 1.
- R10: When `hw_set_valid` coincides with the `out_ack` that completes a state write, the hardware set value is stored and the resolved value is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access request for this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Byte address inside the 4 KiB window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid while host_sel and host_ready are high |
| host_ready | output | 1 | Access completes at the clock edge where host_sel and host_ready are both high |
| host_err | output | 1 | High in the completing cycle of an illegal access |
| err_sticky | output | 1 | Set by any illegal access, cleared only by reset |
| irq | output | 1 | Level interrupt |
| hw_set_valid | input | 1 | Hardware-side load strobe |
| hw_set_value | input | 32 | Value loaded by hw_set_valid |
| out_req | output | 1 | Output write pending toward the hardware side |
| out_value | output | 32 | Value the host asked to write |
| out_ack | input | 1 | Hardware side completes the output write |
| out_resolved | input | 32 | State value the hardware side applied |
| name_copy_req | output | 1 | One-cycle request to copy the name string |
| name_copy_addr | output | 32 | Destination address for the name copy |

## Verification
The bench builds two instances. One is output-capable with a name length of 13, which brings within reach the request/acknowledge stall of varying length, the resolved-equals-current case and the collision between a set and an acknowledge. The other keeps the defaults: input-only, with a name length of 8. It brings within reach the error on a state write and the zero flags word. Random sequences of sets, status reads, enable writes and output writes run on the capable instance against a bench model of the state, the change flag and the enable bit, with the interrupt compared after every operation.

// File: rtl/sw_pkg.sv
// Shared offsets and register select type for the switch state peripheral.
// Assumes word-aligned register offsets inside a byte-addressed window.
package sw_pkg;
    localparam int OFF_NAME_LEN = 'h00;
    localparam int OFF_NAME_PTR = 'h04;
    localparam int OFF_FLAGS    = 'h08;
    localparam int OFF_STATE    = 'h0C;
    localparam int OFF_STATUS   = 'h10;
    localparam int OFF_ENABLE   = 'h14;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_NAME_LEN,
        REG_NAME_PTR,
        REG_FLAGS,
        REG_STATE,
        REG_STATUS,
        REG_ENABLE
    } reg_sel_e;
endpackage

// File: rtl/sw_decode.sv
// Address decoder: maps a host address to a register select and flags
// illegal accesses (bad offset, wrong direction, state write on an
// input-only switch). Purely combinational.
module sw_decode
    import sw_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter bit OUT_CAP = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_sel_e          sel_reg,
    output logic              illegal
);
    // Exact match against aligned offsets; anything else selects nothing.
    always_comb begin
        sel_reg = REG_NONE;
        if (addr == ADDR_W'(OFF_NAME_LEN))      sel_reg = REG_NAME_LEN;
        else if (addr == ADDR_W'(OFF_NAME_PTR)) sel_reg = REG_NAME_PTR;
        else if (addr == ADDR_W'(OFF_FLAGS))    sel_reg = REG_FLAGS;
        else if (addr == ADDR_W'(OFF_STATE))    sel_reg = REG_STATE;
        else if (addr == ADDR_W'(OFF_STATUS))   sel_reg = REG_STATUS;
        else if (addr == ADDR_W'(OFF_ENABLE))   sel_reg = REG_ENABLE;
    end

    // Direction legality per register.
    always_comb begin
        unique case (sel_reg)
            REG_NAME_LEN, REG_FLAGS, REG_STATUS: illegal = wr;
            REG_NAME_PTR, REG_ENABLE:            illegal = !wr;
            REG_STATE:                           illegal = wr && !OUT_CAP;
            default:                             illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sw_out_port.sv
// Output write handshake toward the hardware side. On an output-capable
// build a state write raises a request and stalls the host until the
// acknowledge; otherwise all outputs are tied low.
module sw_out_port #(
    parameter int DATA_W  = 32,
    parameter bit OUT_CAP = 1'b0
) (
    input  logic              wr_state,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    input  logic [DATA_W-1:0] resolved,
    output logic              req,
    output logic [DATA_W-1:0] req_value,
    output logic              stall,
    output logic              upd,
    output logic [DATA_W-1:0] upd_value
);
    generate
        if (OUT_CAP) begin : g_out
            // Request mirrors the pending host write; stall until acknowledged.
            assign req       = wr_state;
            assign req_value = wr_state ? wdata : '0;
            assign stall     = wr_state && !ack;
            assign upd       = wr_state && ack;
            assign upd_value = resolved;
        end else begin : g_in
            logic unused_in;
            // Input-only build: no handshake, inputs intentionally ignored.
            assign unused_in = ^{wr_state, wdata, ack, resolved};
            assign req       = 1'b0;
            assign req_value = '0;
            assign stall     = 1'b0;
            assign upd       = 1'b0;
            assign upd_value = '0;
        end
    endgenerate
endmodule

// File: rtl/sw_state_core.sv
// State, change flag, enable bit and interrupt register. A hardware set
// has priority over an acknowledge update and over a status-read clear.
// Assumes at most one host event (status read or enable write) per cycle.
module sw_state_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [DATA_W-1:0] set_value,
    input  logic              upd_valid,
    input  logic [DATA_W-1:0] upd_value,
    input  logic              status_rd,
    input  logic              en_wr,
    input  logic              en_bit,
    output logic [DATA_W-1:0] state_q,
    output logic              chg_q,
    output logic              en_q,
    output logic              irq_q,
    output logic              status_bit
);
    logic              fire;
    logic [DATA_W-1:0] fire_val;
    logic              en_n;
    logic              chg_n;
    logic              irq_n;

    assign status_bit = chg_q && en_q;

    // Select the winning state source for this cycle.
    always_comb begin
        fire     = set_valid || (upd_valid && (upd_value != state_q));
        fire_val = set_valid ? set_value : upd_value;
    end

    // Next enable, change flag and interrupt level from this cycle's events.
    always_comb begin
        en_n  = en_wr ? en_bit : en_q;
        chg_n = chg_q;
        irq_n = irq_q;
        if (status_rd && status_bit) begin
            chg_n = 1'b0;
            irq_n = 1'b0;
        end
        if (en_wr && chg_q && (en_q != en_bit)) begin
            irq_n = en_bit;
        end
        if (fire) begin
            chg_n = 1'b1;
            if (en_n) irq_n = 1'b1;
        end
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            chg_q   <= 1'b0;
            en_q    <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (fire) state_q <= fire_val;
            chg_q <= chg_n;
            en_q  <= en_n;
            irq_q <= irq_n;
        end
    end
endmodule

// File: rtl/sw_state_periph.sv
// Top of the switch state peripheral: host register window, hardware-side
// set port, output write handshake, name-copy strobe and error reporting.
// Assumes one host access at a time; an access completes at the edge where
// host_sel and host_ready are both high.
module sw_state_periph
    import sw_pkg::*;
#(
    parameter int  DATA_W       = 32,
    parameter int  WINDOW_BYTES = 4096,
    parameter int  NAME_LEN     = 8,
    parameter bit  OUT_CAP      = 1'b0,
    localparam int ADDR_W       = $clog2(WINDOW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              host_err,
    output logic              err_sticky,
    output logic              irq,
    input  logic              hw_set_valid,
    input  logic [DATA_W-1:0] hw_set_value,
    output logic              out_req,
    output logic [DATA_W-1:0] out_value,
    input  logic              out_ack,
    input  logic [DATA_W-1:0] out_resolved,
    output logic              name_copy_req,
    output logic [DATA_W-1:0] name_copy_addr
);
    reg_sel_e          sel_reg;
    logic              illegal;
    logic              good;
    logic              accept;
    logic              wr_state;
    logic              stall;
    logic              upd;
    logic [DATA_W-1:0] upd_value;
    logic [DATA_W-1:0] state_q;
    logic              chg_q;
    logic              en_q;
    logic              status_bit;

    sw_decode #(.ADDR_W(ADDR_W), .OUT_CAP(OUT_CAP)) u_dec (
        .addr    (host_addr),
        .wr      (host_wr),
        .sel_reg (sel_reg),
        .illegal (illegal)
    );

    // Qualify the decoded access.
    assign good       = host_sel && !illegal;
    assign wr_state   = good && host_wr && (sel_reg == REG_STATE);
    assign host_ready = !stall;
    assign accept     = host_sel && host_ready;
    assign host_err   = host_sel && illegal;

    sw_out_port #(.DATA_W(DATA_W), .OUT_CAP(OUT_CAP)) u_out (
        .wr_state  (wr_state),
        .wdata     (host_wdata),
        .ack       (out_ack),
        .resolved  (out_resolved),
        .req       (out_req),
        .req_value (out_value),
        .stall     (stall),
        .upd       (upd),
        .upd_value (upd_value)
    );

    sw_state_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_valid  (hw_set_valid),
        .set_value  (hw_set_value),
        .upd_valid  (upd),
        .upd_value  (upd_value),
        .status_rd  (good && !host_wr && (sel_reg == REG_STATUS)),
        .en_wr      (good && host_wr && (sel_reg == REG_ENABLE)),
        .en_bit     (host_wdata[0]),
        .state_q    (state_q),
        .chg_q      (chg_q),
        .en_q       (en_q),
        .irq_q      (irq),
        .status_bit (status_bit)
    );

    // Read data mux; zero for writes and illegal accesses.
    always_comb begin
        host_rdata = '0;
        if (good && !host_wr) begin
            unique case (sel_reg)
                REG_NAME_LEN: host_rdata = DATA_W'(NAME_LEN);
                REG_FLAGS:    host_rdata = DATA_W'(OUT_CAP);
                REG_STATE:    host_rdata = state_q;
                REG_STATUS:   host_rdata = DATA_W'(status_bit);
                default:      host_rdata = '0;
            endcase
        end
    end

    // Sticky error flag and one-cycle name-copy request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sticky     <= 1'b0;
            name_copy_req  <= 1'b0;
            name_copy_addr <= '0;
        end else begin
            if (host_err) err_sticky <= 1'b1;
            name_copy_req <= accept && good && host_wr && (sel_reg == REG_NAME_PTR);
            if (accept && good && host_wr && (sel_reg == REG_NAME_PTR))
                name_copy_addr <= host_wdata;
        end
    end
endmodule

// File: rtl/sw_periph_checker.sv
// Property checker for sw_state_periph, attached by bind below.
module sw_periph_checker
    import sw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_ready,
    input logic              host_err,
    input logic              err_sticky,
    input logic              irq,
    input logic              hw_set_valid,
    input logic [DATA_W-1:0] hw_set_value,
    input logic              out_req,
    input logic [DATA_W-1:0] out_value,
    input logic              out_ack,
    input logic              name_copy_req,
    input logic [DATA_W-1:0] state_q,
    input logic              chg_q,
    input logic              en_q
);
    logic rd_status;
    logic wr_enable;
    assign rd_status = host_sel && !host_wr && (host_addr == ADDR_W'(OFF_STATUS));
    assign wr_enable = host_sel && host_wr && (host_addr == ADDR_W'(OFF_ENABLE));

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq && !err_sticky && !chg_q && !en_q && state_q == '0)); // R1
    AST_SET_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_valid |=> (state_q == $past(hw_set_value) && chg_q)); // R3
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set_valid && en_q && !(host_sel && host_wr)) |=> irq); // R3
    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && host_rdata[0] && !hw_set_valid) |=> (!irq && !chg_q)); // R4
    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && chg_q && !hw_set_valid) |=> (irq == $past(host_wdata[0]))); // R5
    AST_REQ_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> (host_sel && host_wr && out_value == host_wdata)); // R6
    AST_STALL_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |-> !host_ready); // R6
    AST_ERR_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> err_sticky); // R7
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R7
    AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_err && !hw_set_valid) |=> ($stable(state_q) && $stable(en_q))); // R7
    AST_NAME_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && host_wr && host_addr == ADDR_W'(OFF_NAME_PTR)) |=> name_copy_req); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set_valid && rd_status) |=> chg_q); // R9
endmodule

bind sw_state_periph sw_periph_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_sel      (host_sel),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .host_ready    (host_ready),
    .host_err      (host_err),
    .err_sticky    (err_sticky),
    .irq           (irq),
    .hw_set_valid  (hw_set_valid),
    .hw_set_value  (hw_set_value),
    .out_req       (out_req),
    .out_value     (out_value),
    .out_ack       (out_ack),
    .name_copy_req (name_copy_req),
    .state_q       (state_q),
    .chg_q         (chg_q),
    .en_q          (en_q)
);

// File: tb/tb_sw_state_periph.sv
// Self-checking bench: directed corner cases plus seeded random operations
// on an output-capable instance, and error checks on an input-only one.
module tb_sw_state_periph;
    localparam int NL_A = 13;
    localparam int NL_B = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_a = 1'b0, sel_b = 1'b0;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        hw_set_valid = 1'b0;
    logic [31:0] hw_set_value = '0;
    logic        out_ack = 1'b0;
    logic [31:0] out_resolved = '0;

    logic [31:0] a_rdata, b_rdata, a_out_value, b_out_value, a_ncaddr, b_ncaddr;
    logic        a_ready, b_ready, a_err, b_err, a_sticky, b_sticky, a_irq, b_irq;
    logic        a_out_req, b_out_req, a_ncreq, b_ncreq;

    always #5 clk = ~clk;

    sw_state_periph #(.NAME_LEN(NL_A), .OUT_CAP(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .host_sel(sel_a), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(a_rdata),
        .host_ready(a_ready), .host_err(a_err), .err_sticky(a_sticky), .irq(a_irq),
        .hw_set_valid(hw_set_valid), .hw_set_value(hw_set_value),
        .out_req(a_out_req), .out_value(a_out_value), .out_ack(out_ack),
        .out_resolved(out_resolved), .name_copy_req(a_ncreq), .name_copy_addr(a_ncaddr)
    );

    sw_state_periph dut_ro (
        .clk(clk), .rst_n(rst_n), .host_sel(sel_b), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(b_rdata),
        .host_ready(b_ready), .host_err(b_err), .err_sticky(b_sticky), .irq(b_irq),
        .hw_set_valid(1'b0), .hw_set_value(32'h0),
        .out_req(b_out_req), .out_value(b_out_value), .out_ack(1'b0),
        .out_resolved(32'h0), .name_copy_req(b_ncreq), .name_copy_addr(b_ncaddr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the capable instance.
    logic [31:0] m_state = '0;
    bit          m_chg = 1'b0;
    bit          m_en  = 1'b0;

    function automatic bit exp_irq();
        return m_chg & m_en;
    endfunction

    function automatic logic [31:0] exp_status();
        return {31'b0, m_chg & m_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host access, started at a negedge, ended at the next negedge.
    task automatic acc(input bit tgt, input bit wr, input logic [11:0] a,
                       input logic [31:0] d, output logic [31:0] rd, output logic er);
        host_wr = wr; host_addr = a; host_wdata = d;
        if (tgt) sel_b = 1'b1; else sel_a = 1'b1;
        #1;
        rd = tgt ? b_rdata : a_rdata;
        er = tgt ? b_err : a_err;
        @(posedge clk); #1;
        sel_a = 1'b0; sel_b = 1'b0; host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic hw_set(input logic [31:0] v);
        hw_set_valid = 1'b1; hw_set_value = v;
        @(posedge clk); #1;
        hw_set_valid = 1'b0;
        @(negedge clk);
        m_state = v; m_chg = 1'b1;
    endtask

    // Output write with a stall of nst cycles, then acknowledge with res.
    task automatic state_wr(input logic [31:0] d, input logic [31:0] res, input int nst);
        sel_a = 1'b1; host_wr = 1'b1; host_addr = 12'h00C; host_wdata = d; out_ack = 1'b0;
        #1;
        chk("R6 out_req raised", {31'b0, a_out_req}, 32'd1);
        chk("R6 out_value", a_out_value, d);
        chk("R6 ready low before ack", {31'b0, a_ready}, 32'd0);
        repeat (nst) @(posedge clk);
        #1;
        chk("R6 ready held low", {31'b0, a_ready}, 32'd0);
        out_ack = 1'b1; out_resolved = res;
        #1;
        chk("R6 ready on ack", {31'b0, a_ready}, 32'd1);
        @(posedge clk); #1;
        sel_a = 1'b0; host_wr = 1'b0; out_ack = 1'b0;
        @(negedge clk);
        if (res != m_state) begin m_state = res; m_chg = 1'b1; end
    endtask

    task automatic rd_status_a(input string req);
        logic [31:0] rd; logic er;
        acc(1'b0, 1'b0, 12'h010, 32'h0, rd, er);
        chk(req, rd, exp_status());
        if (m_chg && m_en) m_chg = 1'b0;
    endtask

    task automatic wr_enable_a(input logic [31:0] v);
        logic [31:0] rd; logic er;
        acc(1'b0, 1'b1, 12'h014, v, rd, er);
        m_en = v[0];
    endtask

    task automatic err_case(input bit tgt, input bit wr, input logic [11:0] a, input string req);
        logic [31:0] rd; logic er;
        acc(tgt, wr, a, 32'hFFFF_FFFF, rd, er);
        chk({req, " err pulse"}, {31'b0, er}, 32'd1);
        chk({req, " rdata zero"}, rd, 32'h0);
        chk({req, " sticky"}, {31'b0, tgt ? b_sticky : a_sticky}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        void'($urandom(32'd20240611));

        // R1: reset
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk("R1 irq low", {31'b0, a_irq}, 32'd0);
        chk("R1 sticky low", {31'b0, a_sticky}, 32'd0);
        chk("R1 ro sticky low", {31'b0, b_sticky}, 32'd0);
        chk("R1 out_req low", {31'b0, a_out_req}, 32'd0);
        acc(1'b0, 1'b0, 12'h00C, 32'h0, rd, er); chk("R1 state zero", rd, 32'h0);
        acc(1'b0, 1'b0, 12'h010, 32'h0, rd, er); chk("R1 status zero", rd, 32'h0);
        chk("R1 legal read no error", {31'b0, er}, 32'd0);

        // R2: identification
        acc(1'b0, 1'b0, 12'h000, 32'h0, rd, er); chk("R2 name len capable", rd, NL_A);
        acc(1'b1, 1'b0, 12'h000, 32'h0, rd, er); chk("R2 name len input-only", rd, NL_B);
        acc(1'b0, 1'b0, 12'h008, 32'h0, rd, er); chk("R2 flags capable", rd, 32'h1);
        acc(1'b1, 1'b0, 12'h008, 32'h0, rd, er); chk("R2 flags input-only", rd, 32'h0);

        // R3: set with enable off, then enable with change pending
        hw_set(32'hA5A5_0001);
        chk("R3 no irq while disabled", {31'b0, a_irq}, 32'd0);
        acc(1'b0, 1'b0, 12'h00C, 32'h0, rd, er); chk("R3 state stored", rd, 32'hA5A5_0001);
        rd_status_a("R4 status zero while disabled");
        chk("R4 disabled read keeps irq", {31'b0, a_irq}, 32'd0);
        wr_enable_a(32'h0000_0003);
        chk("R5 irq follows enable with pending change", {31'b0, a_irq}, 32'd1);
        rd_status_a("R4 status reports change");
        chk("R4 read drops irq", {31'b0, a_irq}, 32'd0);
        rd_status_a("R4 second read zero");
        wr_enable_a(32'h0000_0002);
        chk("R5 bit0 only, no change pending", {31'b0, a_irq}, 32'd0);
        hw_set(32'h0000_0077);
        chk("R3 disabled set keeps irq low", {31'b0, a_irq}, 32'd0);
        wr_enable_a(32'h1); chk("R5 enable raises irq", {31'b0, a_irq}, 32'd1);
        wr_enable_a(32'h0); chk("R5 disable drops irq", {31'b0, a_irq}, 32'd0);
        wr_enable_a(32'h1); chk("R5 re-enable raises irq", {31'b0, a_irq}, 32'd1);
        rd_status_a("R4 clear after toggles");
        hw_set(32'h0000_1111);
        chk("R3 enabled set raises irq", {31'b0, a_irq}, 32'd1);
        rd_status_a("R4 clear");

        // R9: set and status read in the same cycle
        hw_set_valid = 1'b1; hw_set_value = 32'h0BAD_F00D;
        sel_a = 1'b1; host_wr = 1'b0; host_addr = 12'h010;
        #1; chk("R9 read returns prior status", a_rdata, 32'h0);
        @(posedge clk); #1; hw_set_valid = 1'b0; sel_a = 1'b0; @(negedge clk);
        m_state = 32'h0BAD_F00D; m_chg = 1'b1;
        chk("R9 set wins, irq high", {31'b0, a_irq}, 32'd1);
        hw_set_valid = 1'b1; hw_set_value = 32'h0BAD_F00E;
        sel_a = 1'b1; host_addr = 12'h010;
        #1; chk("R9 pending read returns one", a_rdata, 32'h1);
        @(posedge clk); #1; hw_set_valid = 1'b0; sel_a = 1'b0; @(negedge clk);
        m_state = 32'h0BAD_F00E; m_chg = 1'b1;
        chk("R9 irq stays high", {31'b0, a_irq}, 32'd1);
        rd_status_a("R9 change still pending");

        // R6: output write handshake
        state_wr(32'h1234_5678, 32'h1234_5600, 3);
        chk("R6 differing value raises irq", {31'b0, a_irq}, 32'd1);
        acc(1'b0, 1'b0, 12'h00C, 32'h0, rd, er); chk("R6 resolved stored", rd, 32'h1234_5600);
        rd_status_a("R6 change flagged");
        state_wr(32'hFFFF_0000, 32'h1234_5600, 0);
        chk("R6 equal value no irq", {31'b0, a_irq}, 32'd0);
        rd_status_a("R6 equal value no change");

        // R10: hardware set collides with acknowledge
        sel_a = 1'b1; host_wr = 1'b1; host_addr = 12'h00C; host_wdata = 32'h1;
        out_ack = 1'b1; out_resolved = 32'h0000_BEEF;
        hw_set_valid = 1'b1; hw_set_value = 32'hDEAD_0000;
        @(posedge clk); #1;
        sel_a = 1'b0; host_wr = 1'b0; out_ack = 1'b0; hw_set_valid = 1'b0;
        @(negedge clk);
        m_state = 32'hDEAD_0000; m_chg = 1'b1;
        acc(1'b0, 1'b0, 12'h00C, 32'h0, rd, er); chk("R10 hardware value wins", rd, 32'hDEAD_0000);

        // R8: name copy strobe
        acc(1'b0, 1'b1, 12'h004, 32'h0000_4000, rd, er);
        chk("R8 copy request", {31'b0, a_ncreq}, 32'd1);
        chk("R8 copy address", a_ncaddr, 32'h0000_4000);
        @(negedge clk);
        chk("R8 single cycle", {31'b0, a_ncreq}, 32'd0);

        // R7: errors, with a change still pending on the capable instance
        chk("R7 sticky clear before error", {31'b0, a_sticky}, 32'd0);
        err_case(1'b0, 1'b0, 12'h004, "R7 read name ptr");
        err_case(1'b0, 1'b0, 12'h014, "R7 read enable");
        err_case(1'b0, 1'b1, 12'h000, "R7 write name len");
        err_case(1'b0, 1'b1, 12'h008, "R7 write flags");
        err_case(1'b0, 1'b1, 12'h010, "R7 write status");
        chk("R7 status write no effect on irq", {31'b0, a_irq}, 32'd1);
        err_case(1'b0, 1'b0, 12'h00D, "R7 unaligned");
        err_case(1'b0, 1'b0, 12'h018, "R7 past last reg");
        err_case(1'b0, 1'b1, 12'hFFC, "R7 top of window");
        chk("R7 no name strobe on error", {31'b0, a_ncreq}, 32'd0);
        rd_status_a("R7 change survives errors");
        acc(1'b0, 1'b0, 12'h00C, 32'h0, rd, er); chk("R7 state untouched", rd, 32'hDEAD_0000);
        chk("R7 sticky holds", {31'b0, a_sticky}, 32'd1);
        err_case(1'b1, 1'b1, 12'h00C, "R7 state write input-only");
        chk("R7 input-only no request", {31'b0, b_out_req}, 32'd0);
        acc(1'b1, 1'b0, 12'h00C, 32'h0, rd, er); chk("R7 input-only state unchanged", rd, 32'h0);

        // Random phase on the capable instance
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [31:0] v;
            op = $urandom_range(0, 5);
            v  = ($urandom_range(0, 3) == 0) ? m_state : $urandom();
            case (op)
                0: hw_set(v);
                1: rd_status_a("R4 random status");
                2: wr_enable_a($urandom());
                3: state_wr($urandom(), v, $urandom_range(0, 3));
                4: begin
                    acc(1'b0, 1'b0, 12'h00C, 32'h0, rd, er);
                    chk("R3 random state read", rd, m_state);
                    chk("R7 random legal read no error", {31'b0, er}, 32'd0);
                end
                default: begin
                    hw_set_valid = 1'b1; hw_set_value = v;
                    sel_a = 1'b1; host_wr = 1'b0; host_addr = 12'h010;
                    #1; chk("R9 random collision read", a_rdata, exp_status());
                    @(posedge clk); #1; hw_set_valid = 1'b0; sel_a = 1'b0; @(negedge clk);
                    m_state = v; m_chg = 1'b1;
                end
            endcase
            chk("R5 random irq level", {31'b0, a_irq}, {31'b0, exp_irq()});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule